// File: doc/BRIEF.md
# Tile Test-Access Router

This block sits in every tile of a row of tiles and steers the serial test data path. Inside the tile it links fourteen core debug ports, either one after another so that a single test interface reaches every core, or side by side so that one serial stream programs all cores at once while only the first core's output is returned. At the tile boundary it either passes the tile's serial output on to the next tile downstream, or turns it around onto the return line heading back toward the test controller. The test clock and the mode-select line are shared by every tile of the row.

The tile has a small test access controller of its own that follows the shared mode-select line. Its instruction register selects either a one-bit pass-through stage or a two-bit routing register; the routing register holds a broadcast bit and a forward bit. A written routing value is held as pending and becomes the live routing only when the controller reaches the idle state, so an ongoing shift never sees its path change. Every tile wakes up turned around. A controller brings up a row by testing the nearest tile, switching it to forward, and so exposing the next tile, which is still turned around.

Top module: `tile_scan_router`

## Requirements
- R1: After `trst_n` is released the tile is in series mode with turn-around: `port_tdi[i]` equals `port_tdo[i-1]` for i above 0, `tdi_down` is 0, and `ret_out` does not follow `ret_in`.
- R2: In series mode the tile's own one-bit stage and then ports 0 to 13 are in line, so with the pass-through instruction a bit on `tdi_in` reaches the tile output after 1 plus the sum of the port lengths rising edges.
- R3: In broadcast mode every `port_tdi` bit carries the tile's own stage output, and the tile output is `port_tdo[0]`, giving a latency of 1 plus the length of port 0.
- R4: With the forward bit clear, `ret_out` carries the tile output and `tdi_down` is held at 0.
- R5: With the forward bit set, `tdi_down` carries the tile output and `ret_out` follows `ret_in` directly.
- R6: The routing register is selected by the 4-bit instruction 4'b0010; its first shifted bit lands in bit 0 (broadcast) and its second in bit 1 (forward), and it writes the pending routing on Update-DR.
- R7: A pending routing becomes live only on a rising edge at which the controller is in Run-Test/Idle; passing from Update-DR straight back into a new scan leaves the old routing in place.
- R8: Five rising edges with `tms` high reach Test-Logic-Reset, which restores series mode with turn-around and selects the pass-through instruction.
- R9: Any instruction other than 4'b0010 selects the one-bit pass-through stage, and a data scan under it leaves the routing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Shared test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Shared mode select |
| tdi_in | input | 1 | Serial data from the upstream tile or the controller |
| ret_in | input | 1 | Return line arriving from the downstream tile |
| tdi_down | output | 1 | Serial data toward the downstream tile |
| ret_out | output | 1 | Return line toward the upstream tile or the controller |
| port_tdi | output | 14 | Serial data into each core debug port |
| port_tdo | input | 14 | Serial data out of each core debug port |

## Verification
The core ports are stood in for by shift registers of lengths 1, 2 and 3 in turn, so series mode shows a 28-edge latency while broadcast shows 2; a wrong link order, a missing stage or a broadcast that still chains would each move the delay. Random bit streams are compared on `ret_out` while turned around and on `tdi_down` while forwarding, with `ret_in` toggled to tell the return pass-through apart from the tile output. A routing write followed by a direct re-entry into a scan, and a write under a foreign instruction, separate a correct deferred update from an early or unguarded one, and a reset via `tms` alone shows that defaults come back without `trst_n`.

// File: rtl/tile_scan_router_pkg.sv
package tile_scan_router_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_t;

  typedef struct packed {
    logic fwd;
    logic bcast;
  } route_t;

  function automatic tap_st_t tap_next(tap_st_t s, logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  // bit 0 of the scanned register is broadcast, bit 1 is forward
  function automatic route_t route_from_bits(logic [1:0] b);
    route_t r;
    r.bcast = b[0];
    r.fwd   = b[1];
    return r;
  endfunction

  function automatic logic [1:0] route_to_bits(route_t r);
    return {r.fwd, r.bcast};
  endfunction

endpackage

// File: rtl/tsr_tap.sv
module tsr_tap
  import tile_scan_router_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_t st
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= tap_next(st, tms);
  end

endmodule

// File: rtl/tsr_regs.sv
module tsr_regs
  import tile_scan_router_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] OP_CFG = 4'b0010,
  parameter logic [IR_W-1:0] OP_BYP = '1
) (
  input  logic    tck,
  input  logic    trst_n,
  input  tap_st_t st,
  input  logic    tdi,
  output logic    seg_out,
  output route_t  route_pend,
  output route_t  route_act,
  output logic    upd_cfg,
  output logic    apply_now
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  logic [IR_W-1:0] ir_sh, ir_q;
  logic [1:0]      cfg_sh;
  logic            byp_q;
  logic            cfg_sel;

  assign cfg_sel   = (ir_q == OP_CFG);
  assign upd_cfg   = (st == ST_UPD_DR) && cfg_sel;
  assign apply_now = (st == ST_RTI);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_BYP;
    end else begin
      if (st == ST_CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (st == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (st == ST_TLR)        ir_q  <= OP_BYP;
      else if (st == ST_UPD_IR) ir_q <= ir_sh;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q  <= 1'b0;
      cfg_sh <= 2'b00;
    end else begin
      if (st == ST_CAP_DR)     byp_q <= 1'b0;
      else if (st == ST_SH_DR) byp_q <= tdi;
      if (cfg_sel && st == ST_CAP_DR)     cfg_sh <= route_to_bits(route_pend);
      else if (cfg_sel && st == ST_SH_DR) cfg_sh <= {tdi, cfg_sh[1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      route_pend <= '0;
      route_act  <= '0;
    end else if (st == ST_TLR) begin
      route_pend <= '0;
      route_act  <= '0;
    end else begin
      if (upd_cfg)   route_pend <= route_from_bits(cfg_sh);
      if (apply_now) route_act  <= route_pend;
    end
  end

  always_comb begin
    if (st == ST_SH_IR) seg_out = ir_sh[0];
    else if (cfg_sel)   seg_out = cfg_sh[0];
    else                seg_out = byp_q;
  end

endmodule

// File: rtl/tsr_route.sv
module tsr_route
  import tile_scan_router_pkg::*;
#(
  parameter int NPORT = 14
) (
  input  logic             seg_out,
  input  route_t           route_act,
  input  logic [NPORT-1:0] port_tdo,
  input  logic             ret_in,
  output logic [NPORT-1:0] port_tdi,
  output logic             tile_tdo,
  output logic             tdi_down,
  output logic             ret_out
);

  for (genvar i = 0; i < NPORT; i++) begin : g_link
    if (i == 0) begin : g_head
      assign port_tdi[i] = seg_out;
    end else begin : g_body
      assign port_tdi[i] = route_act.bcast ? seg_out : port_tdo[i-1];
    end
  end

  assign tile_tdo = route_act.bcast ? port_tdo[0] : port_tdo[NPORT-1];
  assign tdi_down = route_act.fwd ? tile_tdo : 1'b0;
  assign ret_out  = route_act.fwd ? ret_in : tile_tdo;

endmodule

// File: rtl/tile_scan_router.sv
module tile_scan_router
  import tile_scan_router_pkg::*;
#(
  parameter int              NPORT  = 14,
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] OP_CFG = 4'b0010,
  parameter logic [IR_W-1:0] OP_BYP = '1
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi_in,
  input  logic             ret_in,
  output logic             tdi_down,
  output logic             ret_out,
  output logic [NPORT-1:0] port_tdi,
  input  logic [NPORT-1:0] port_tdo
);

  tap_st_t tap_st;
  route_t  route_act, route_pend;
  logic    seg_out, tile_tdo, upd_cfg, apply_now;

  tsr_tap u_tap (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .st     (tap_st)
  );

  tsr_regs #(.IR_W(IR_W), .OP_CFG(OP_CFG), .OP_BYP(OP_BYP)) u_regs (
    .tck        (tck),
    .trst_n     (trst_n),
    .st         (tap_st),
    .tdi        (tdi_in),
    .seg_out    (seg_out),
    .route_pend (route_pend),
    .route_act  (route_act),
    .upd_cfg    (upd_cfg),
    .apply_now  (apply_now)
  );

  tsr_route #(.NPORT(NPORT)) u_route (
    .seg_out   (seg_out),
    .route_act (route_act),
    .port_tdo  (port_tdo),
    .ret_in    (ret_in),
    .port_tdi  (port_tdi),
    .tile_tdo  (tile_tdo),
    .tdi_down  (tdi_down),
    .ret_out   (ret_out)
  );

endmodule

// File: rtl/tile_scan_router_chk.sv
module tile_scan_router_chk
  import tile_scan_router_pkg::*;
#(
  parameter int NPORT = 14
) (
  input logic             tck,
  input logic             trst_n,
  input tap_st_t          st,
  input route_t           route_act,
  input route_t           route_pend,
  input logic             upd_cfg,
  input logic             apply_now,
  input logic [NPORT-1:0] port_tdi,
  input logic             tile_tdo,
  input logic             ret_in,
  input logic             ret_out,
  input logic             tdi_down
);

  AST_APPLY_IN_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
    (route_act != $past(route_act)) |-> ($past(apply_now) || $past(st) == ST_TLR)); // R7

  AST_PEND_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (route_pend != $past(route_pend)) |-> ($past(upd_cfg) || $past(st) == ST_TLR)); // R6

  AST_TLR_DEFAULTS: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |=> (route_act == '0 && route_pend == '0)); // R8

  AST_BCAST_FANOUT: assert property (@(posedge tck) disable iff (!trst_n)
    route_act.bcast |-> ($countones(port_tdi) == 0 || $countones(port_tdi) == NPORT)); // R3

  AST_FWD_RETURN: assert property (@(posedge tck) disable iff (!trst_n)
    route_act.fwd |-> (ret_out == ret_in && tdi_down == tile_tdo)); // R5

  AST_LOOP_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    !route_act.fwd |-> (tdi_down == 1'b0 && ret_out == tile_tdo)); // R4

endmodule

bind tile_scan_router tile_scan_router_chk #(.NPORT(NPORT)) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .st         (tap_st),
  .route_act  (route_act),
  .route_pend (route_pend),
  .upd_cfg    (upd_cfg),
  .apply_now  (apply_now),
  .port_tdi   (port_tdi),
  .tile_tdo   (tile_tdo),
  .ret_in     (ret_in),
  .ret_out    (ret_out),
  .tdi_down   (tdi_down)
);

// File: tb/tile_scan_router_test.sv
module tile_scan_router_test;

  localparam int TCK_PERIOD = 10;
  localparam int NPORT = 14;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_CFG = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYP = 4'b1111;
  localparam logic [IR_W-1:0] OP_OTHER = 4'b0101;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi_in = 1'b0, ret_in = 1'b0;
  logic tdi_down, ret_out;
  logic [NPORT-1:0] port_tdi, port_tdo;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  bit exp_q[$];

  always #(TCK_PERIOD/2) tck = ~tck;

  tile_scan_router #(.NPORT(NPORT)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi_in(tdi_in), .ret_in(ret_in),
    .tdi_down(tdi_down), .ret_out(ret_out), .port_tdi(port_tdi), .port_tdo(port_tdo)
  );

  // core debug port stand-ins: shift registers of length 1,2,3,1,2,3,...
  function automatic int plen(int i);
    return 1 + (i % 3);
  endfunction

  function automatic int chain_sum();
    int s = 0;
    for (int i = 0; i < NPORT; i++) s += plen(i);
    return s;
  endfunction

  logic [2:0] pm [NPORT];
  initial for (int i = 0; i < NPORT; i++) pm[i] = 3'b000;
  always @(posedge tck)
    for (int i = 0; i < NPORT; i++)
      pm[i] <= (pm[i] >> 1) | ({2'b00, port_tdi[i]} << (plen(i) - 1));
  always_comb for (int i = 0; i < NPORT; i++) port_tdo[i] = pm[i][0];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit m);
    @(negedge tck);
    tms = m;
  endtask

  task automatic set_ir(logic [IR_W-1:0] op);
    step(1); step(1); step(0); step(0);
    for (int k = 0; k < IR_W; k++) begin
      @(negedge tck);
      tdi_in = op[k];
      tms = (k == IR_W - 1);
    end
    step(1); step(0); step(0);
  endtask

  // scan two bits: b[0] first (broadcast), b[1] second (forward); ends in Update-DR
  task automatic write_dr2(logic [1:0] b);
    step(1); step(0); step(0);
    @(negedge tck); tdi_in = b[0]; tms = 1'b0;
    @(negedge tck); tdi_in = b[1]; tms = 1'b1;
    step(1);
  endtask

  task automatic to_idle_applied();
    step(0); step(0);
  endtask

  task automatic loop_check(string req);
    logic a, b;
    ret_in = 1'b0; #1; a = ret_out;
    ret_in = 1'b1; #1; b = ret_out;
    check(a == b, req, "ret_out independent of ret_in", int'(b), int'(a));
    check(tdi_down == 1'b0, req, "tdi_down quiet", int'(tdi_down), 0);
  endtask

  task automatic fwd_check(string req);
    ret_in = 1'b0; #1;
    check(ret_out == 1'b0, req, "ret_out follows ret_in=0", int'(ret_out), 0);
    ret_in = 1'b1; #1;
    check(ret_out == 1'b1, req, "ret_out follows ret_in=1", int'(ret_out), 1);
  endtask

  // driver pushes each bit it applies; the monitor pops it once lat edges have passed
  task automatic stream(int n, int lat, bit use_down, bit chk_bcast, bit chk_ret, string req);
    exp_q.delete();
    for (int k = 0; k < n; k++) begin
      bit b, e, obs;
      @(negedge tck);
      if (exp_q.size() == lat) begin
        e = exp_q.pop_front();
        obs = use_down ? tdi_down : ret_out;
        check(obs == e, req, use_down ? "tdi_down bit" : "ret_out bit", int'(obs), int'(e));
      end
      if (chk_bcast)
        check(port_tdi == '0 || port_tdi == '1, req, "port_tdi fan-out", int'(port_tdi), 0);
      if (chk_ret) begin
        check(ret_out == ret_in, req, "return pass-through", int'(ret_out), int'(ret_in));
        ret_in = 1'($urandom);
      end
      b = 1'($urandom);
      tdi_in = b;
      tms = 1'b0;
      exp_q.push_back(b);
    end
  endtask

  task automatic enter_shift_dr();
    step(1); step(0); step(0);
  endtask

  task automatic leave_shift_dr();
    step(1); step(1); step(0); step(0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam int LAT_SER = 1 + 27;
  localparam int LAT_BC  = 1 + 1;

  initial begin
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    #1;
    // R1: reset state
    for (int i = 1; i < NPORT; i++)
      check(port_tdi[i] == port_tdo[i-1], "R1", "series link after reset",
            int'(port_tdi[i]), int'(port_tdo[i-1]));
    loop_check("R1");
    check(chain_sum() == 27, "R2", "model chain length", chain_sum(), 27);
    step(0); step(0);

    // R2 / R4: series, turned around
    enter_shift_dr();
    stream(80, LAT_SER, 1'b0, 1'b0, 1'b0, "R2");
    @(negedge tck);
    check(tdi_down == 1'b0, "R4", "tdi_down held while turned around", int'(tdi_down), 0);
    leave_shift_dr();

    // R6 / R3: broadcast via routing register
    set_ir(OP_CFG);
    write_dr2(2'b01);
    to_idle_applied();
    set_ir(OP_BYP);
    enter_shift_dr();
    stream(40, LAT_BC, 1'b0, 1'b1, 1'b0, "R3");
    leave_shift_dr();
    loop_check("R6");

    // R7: write forward, then scan again without passing idle
    set_ir(OP_CFG);
    write_dr2(2'b10);
    step(1);
    @(posedge tck); #1;
    loop_check("R7");
    step(0); step(1); step(1); step(0);
    @(posedge tck); #1;
    loop_check("R7");
    step(0);
    @(posedge tck); #1;
    fwd_check("R7");

    // R5: forward, series
    set_ir(OP_BYP);
    enter_shift_dr();
    stream(80, LAT_SER, 1'b1, 1'b0, 1'b1, "R5");
    leave_shift_dr();

    // R5 / R6: forward and broadcast together
    set_ir(OP_CFG);
    write_dr2(2'b11);
    to_idle_applied();
    set_ir(OP_BYP);
    enter_shift_dr();
    stream(40, LAT_BC, 1'b1, 1'b1, 1'b1, "R5");
    leave_shift_dr();

    // R8: reset through tms alone
    for (int k = 0; k < 5; k++) step(1);
    step(0); step(0);
    @(posedge tck); #1;
    loop_check("R8");
    enter_shift_dr();
    stream(60, LAT_SER, 1'b0, 1'b0, 1'b0, "R8");
    leave_shift_dr();

    // R9: foreign instruction leaves routing alone and gives a one-bit stage
    set_ir(OP_OTHER);
    write_dr2(2'b11);
    to_idle_applied();
    @(posedge tck); #1;
    loop_check("R9");
    enter_shift_dr();
    stream(60, LAT_SER, 1'b0, 1'b0, 1'b0, "R9");
    leave_shift_dr();

    finish_run();
  end

endmodule